// File: doc/BRIEF.md
# Split-Freeze Real-Time Counter with Alarm and Periodic Timer

This block is a timer peripheral behind a small word-addressed register port. Its core is a free-running real-time counter, 40 bits by default, which advances by one on every cycle where the `tick` clock enable is high. Software reads it as a lower word and an upper word. The upper and lower parts can be stopped independently, and a clear bit holds the whole counter at zero.

The same counter feeds a full-width alarm comparator and a rollover detector. A separate reloadable down-counter, stepped by the same tick, gives a periodic expiry. Each of the three events sets a sticky status bit. Software clears a bit by writing 1 to it. A per-bit enable gates each status bit onto its interrupt output. The lower word is a single register, so one read of it is always coherent. The two words are not latched together, so software reading both words must re-read until two reads agree.

Register word offsets on `bus_addr`: 0 control, 1 counter lower word, 2 counter upper word, 3 alarm lower word, 4 alarm upper word, 5 period reload, 6 interrupt status, 7 interrupt enable.

Top module: `rtc_alarm_timer`

## Requirements
- R1: On each cycle with `tick` high, the counter increments by one unless the clear bit or the lower-freeze bit is set. Offset 1 reads counter bits LO_W-1:0. Offset 2 reads the upper HI_W bits in its low bits, with zeros above them.
- R2: Control bit 0 freezes the lower counter part. Control bit 1 freezes the upper part. A frozen part keeps its value through ticks while the other part can still move.
- R3: While control bit 2 (clear) is set, the counter reads zero and does not count. After the bit is written back to 0, counting restarts from zero.
- R4: Control bit 3 enables the periodic timer and bit 4 freezes it. While the enable bit is 0, which includes after a write of 0 to the whole control register, the period status is never set and the down-counter is reloaded with the period value. While frozen, ticks produce no expiry. The control register reads back at offset 0.
- R5: With value N-1 in the period register (offset 5), an enabled and unfrozen periodic timer sets the period status once every N ticks, with the first expiry on the Nth tick after enabling.
- R6: The alarm lower word is at offset 3. The alarm upper word is at offset 4 and is masked to HI_W bits on write, so it reads back with zeros above them. The alarm status is set on the tick where the counter becomes equal to the alarm value.
- R7: Interrupt status at offset 6 has rollover at bit 31, alarm at bit 30 and period expiry at bit 29. All bits are zero after reset.
- R8: The rollover status is set when the full counter steps from all ones to zero.
- R9: Status bits are sticky. Writing 1 to a status bit clears it, and writing 0 to it leaves it unchanged.
- R10: The interrupt enable register at offset 7 uses the same bit positions as the status register. An output `irq_*` is high exactly when its status bit and its enable bit are both set.
- R11: When the upper part is frozen, the carry out of the lower part is dropped: the lower part wraps to zero, the upper part keeps its value and no rollover is flagged.
- R12: The alarm compare is made only when the counter changes. While the counter holds a matching value, a cleared alarm status stays clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable for the counter and the periodic timer |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` |
| irq_wrap | output | 1 | Rollover interrupt request |
| irq_alarm | output | 1 | Alarm interrupt request |
| irq_period | output | 1 | Periodic expiry interrupt request |

## Verification
The hardest states to reach from the ports are the full-width wrap and the carry into a frozen upper part. The counter cannot be loaded, so with default widths these states lie 2^32 or 2^40 ticks away. The bench builds the block with an 8-bit lower part and a 4-bit upper part and holds `tick` high for long runs. This reaches the carry drop after 256 ticks and a full wrap after 4096 ticks. The alarm-once rule is covered by clearing the alarm status while the counter rests on the matching value, first idle and then with the lower part frozen under ticks.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
   typedef enum logic [2:0] {
      REG_CTRL   = 3'd0,
      REG_CNT_LO = 3'd1,
      REG_CNT_HI = 3'd2,
      REG_ALM_LO = 3'd3,
      REG_ALM_HI = 3'd4,
      REG_PERIOD = 3'd5,
      REG_STATUS = 3'd6,
      REG_IRQEN  = 3'd7
   } reg_off_e;

   localparam int CTL_FRZ_LO  = 0;
   localparam int CTL_FRZ_HI  = 1;
   localparam int CTL_CLEAR   = 2;
   localparam int CTL_PER_EN  = 3;
   localparam int CTL_PER_FRZ = 4;
   localparam int CTL_W       = 5;

   localparam int NUM_EVT = 3;
   localparam int EVT_PER   = 0;
   localparam int EVT_ALARM = 1;
   localparam int EVT_WRAP  = 2;
   localparam int EVT_LSB   = 29;
endpackage

// File: rtl/rtc_count.sv
module rtc_count #(
   parameter int LO_W = 32,
   parameter int HI_W = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tick,
   input  logic            clr,
   input  logic            frz_lo,
   input  logic            frz_hi,
   input  logic [LO_W-1:0] alm_lo,
   input  logic [HI_W-1:0] alm_hi,
   output logic [LO_W-1:0] cnt_lo,
   output logic [HI_W-1:0] cnt_hi,
   output logic            wrap,
   output logic            match
);
   logic            step_lo, step_hi;
   logic [LO_W-1:0] lo_nxt;
   logic [HI_W-1:0] hi_nxt;

   assign step_lo = tick & ~clr & ~frz_lo;
   assign step_hi = step_lo & (&cnt_lo) & ~frz_hi;
   assign lo_nxt  = cnt_lo + LO_W'(1);
   assign hi_nxt  = step_hi ? cnt_hi + HI_W'(1) : cnt_hi;
   assign wrap    = step_hi & (&cnt_hi);
   assign match   = step_lo & (lo_nxt == alm_lo) & (hi_nxt == alm_hi);

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         cnt_lo <= '0;
         cnt_hi <= '0;
      end else begin
         if (step_lo) cnt_lo <= lo_nxt;
         cnt_hi <= hi_nxt;
      end
   end
endmodule

// File: rtl/rtc_period.sv
module rtc_period #(
   parameter int PER_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             en,
   input  logic             frz,
   input  logic [PER_W-1:0] reload,
   output logic             expire
);
   logic [PER_W-1:0] down_q;

   assign expire = en & tick & ~frz & (down_q == '0);

   always_ff @(posedge clk) begin
      if (!rst_n)                  down_q <= '0;
      else if (!en || expire)      down_q <= reload;
      else if (tick && !frz)       down_q <= down_q - PER_W'(1);
   end
endmodule

// File: rtl/rtc_irq.sv
module rtc_irq #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic [N-1:0] w1c,
   input  logic [N-1:0] en,
   output logic [N-1:0] status,
   output logic [N-1:0] irq
);
   for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!rst_n)      status[i] <= 1'b0;
         else if (set[i]) status[i] <= 1'b1;
         else if (w1c[i]) status[i] <= 1'b0;
      end
      assign irq[i] = status[i] & en[i];
   end
endmodule

// File: rtl/rtc_alarm_timer.sv
module rtc_alarm_timer
   import rtc_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int CNT_LO_W = 32,
   parameter int CNT_HI_W = 8,
   parameter int PER_W    = 16,
   parameter bit RD_PIPE  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              bus_wr,
   input  logic [2:0]        bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq_wrap,
   output logic              irq_alarm,
   output logic              irq_period
);
   localparam int EVT_MSB = EVT_LSB + NUM_EVT - 1;

   if (DATA_W < 32) begin : g_bad_data
      $error("DATA_W must be at least 32");
   end
   if (CNT_LO_W > DATA_W || CNT_HI_W > DATA_W || PER_W > DATA_W) begin : g_bad_width
      $error("counter fields must fit a data word");
   end
   if (CNT_LO_W < 2 || CNT_HI_W < 1 || PER_W < 1) begin : g_bad_min
      $error("counter widths too small");
   end

   logic [CTL_W-1:0]    ctrl_q;
   logic [CNT_LO_W-1:0] alm_lo_q, cnt_lo;
   logic [CNT_HI_W-1:0] alm_hi_q, cnt_hi;
   logic [PER_W-1:0]    period_q;
   logic [NUM_EVT-1:0]  irqen_q, status, irq, set, w1c;
   logic                c_clr, c_frz_lo, c_frz_hi, c_per_en, c_per_frz;
   logic                wrap, match, expire;
   logic [DATA_W-1:0]   rd_mux;

   assign c_clr     = ctrl_q[CTL_CLEAR];
   assign c_frz_lo  = ctrl_q[CTL_FRZ_LO];
   assign c_frz_hi  = ctrl_q[CTL_FRZ_HI];
   assign c_per_en  = ctrl_q[CTL_PER_EN];
   assign c_per_frz = ctrl_q[CTL_PER_FRZ];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q   <= '0;
         alm_lo_q <= '0;
         alm_hi_q <= '0;
         period_q <= '0;
         irqen_q  <= '0;
      end else if (bus_wr) begin
         case (reg_off_e'(bus_addr))
            REG_CTRL:   ctrl_q   <= bus_wdata[CTL_W-1:0];
            REG_ALM_LO: alm_lo_q <= bus_wdata[CNT_LO_W-1:0];
            REG_ALM_HI: alm_hi_q <= bus_wdata[CNT_HI_W-1:0];
            REG_PERIOD: period_q <= bus_wdata[PER_W-1:0];
            REG_IRQEN:  irqen_q  <= bus_wdata[EVT_MSB:EVT_LSB];
            default: ;
         endcase
      end
   end

   rtc_count #(.LO_W(CNT_LO_W), .HI_W(CNT_HI_W)) u_count (
      .clk(clk), .rst_n(rst_n), .tick(tick), .clr(c_clr),
      .frz_lo(c_frz_lo), .frz_hi(c_frz_hi),
      .alm_lo(alm_lo_q), .alm_hi(alm_hi_q),
      .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .wrap(wrap), .match(match)
   );

   rtc_period #(.PER_W(PER_W)) u_period (
      .clk(clk), .rst_n(rst_n), .tick(tick), .en(c_per_en),
      .frz(c_per_frz), .reload(period_q), .expire(expire)
   );

   always_comb begin
      set = '0;
      set[EVT_WRAP]  = wrap;
      set[EVT_ALARM] = match;
      set[EVT_PER]   = expire;
   end
   assign w1c = (bus_wr && reg_off_e'(bus_addr) == REG_STATUS)
                ? bus_wdata[EVT_MSB:EVT_LSB] : '0;

   rtc_irq #(.N(NUM_EVT)) u_irq (
      .clk(clk), .rst_n(rst_n), .set(set), .w1c(w1c), .en(irqen_q),
      .status(status), .irq(irq)
   );

   assign irq_wrap   = irq[EVT_WRAP];
   assign irq_alarm  = irq[EVT_ALARM];
   assign irq_period = irq[EVT_PER];

   always_comb begin
      rd_mux = '0;
      case (reg_off_e'(bus_addr))
         REG_CTRL:   rd_mux[CTL_W-1:0]       = ctrl_q;
         REG_CNT_LO: rd_mux[CNT_LO_W-1:0]    = cnt_lo;
         REG_CNT_HI: rd_mux[CNT_HI_W-1:0]    = cnt_hi;
         REG_ALM_LO: rd_mux[CNT_LO_W-1:0]    = alm_lo_q;
         REG_ALM_HI: rd_mux[CNT_HI_W-1:0]    = alm_hi_q;
         REG_PERIOD: rd_mux[PER_W-1:0]       = period_q;
         REG_STATUS: rd_mux[EVT_MSB:EVT_LSB] = status;
         REG_IRQEN:  rd_mux[EVT_MSB:EVT_LSB] = irqen_q;
         default: ;
      endcase
   end

   if (RD_PIPE) begin : g_rd_reg
      always_ff @(posedge clk) begin
         if (!rst_n) bus_rdata <= '0;
         else        bus_rdata <= rd_mux;
      end
   end else begin : g_rd_comb
      assign bus_rdata = rd_mux;
   end
endmodule

// File: rtl/rtc_alarm_timer_chk.sv
module rtc_alarm_timer_chk #(
   parameter int LO_W = 32,
   parameter int HI_W = 8
) (
   input logic            clk,
   input logic            rst_n,
   input logic            tick,
   input logic            clr,
   input logic            frz_lo,
   input logic            frz_hi,
   input logic            per_en,
   input logic [LO_W-1:0] cnt_lo,
   input logic [HI_W-1:0] cnt_hi,
   input logic [LO_W-1:0] alm_lo,
   input logic [HI_W-1:0] alm_hi,
   input logic [2:0]      status
);
   assert_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !clr && !frz_lo) |=> (cnt_lo == $past(cnt_lo) + LO_W'(1)));

   assert_lo_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (frz_lo && !clr) |=> $stable(cnt_lo));

   assert_hi_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (frz_hi && !clr) |=> $stable(cnt_hi));

   assert_clear_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt_lo == '0 && cnt_hi == '0));

   assert_per_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !per_en |=> !$rose(status[0]));

   assert_alarm_equal_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[1]) |-> ({cnt_hi, cnt_lo} == $past({alm_hi, alm_lo})));

   assert_alarm_on_change_R12: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[1]) |-> ({cnt_hi, cnt_lo} != $past({cnt_hi, cnt_lo})));

   assert_carry_drop_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !clr && !frz_lo && frz_hi && (&cnt_lo)) |=> (cnt_lo == '0 && !$rose(status[2])));
endmodule

bind rtc_alarm_timer rtc_alarm_timer_chk #(.LO_W(CNT_LO_W), .HI_W(CNT_HI_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .tick(tick), .clr(c_clr),
   .frz_lo(c_frz_lo), .frz_hi(c_frz_hi), .per_en(c_per_en),
   .cnt_lo(cnt_lo), .cnt_hi(cnt_hi), .alm_lo(alm_lo_q), .alm_hi(alm_hi_q),
   .status(status)
);

// File: tb/test_rtc_alarm_timer.sv
module test_rtc_alarm_timer;
   localparam int LO_W = 8;
   localparam int HI_W = 4;
   localparam logic [31:0] S_WRAP  = 32'h8000_0000;
   localparam logic [31:0] S_ALARM = 32'h4000_0000;
   localparam logic [31:0] S_PER   = 32'h2000_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic        bus_wr = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_wrap, irq_alarm, irq_period;

   int total = 0;
   int bad = 0;

   always #10 clk = ~clk;

   rtc_alarm_timer #(.DATA_W(32), .CNT_LO_W(LO_W), .CNT_HI_W(HI_W), .PER_W(8)) i_rtc_alarm_timer (
      .clk(clk), .rst_n(rst_n), .tick(tick), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_wrap(irq_wrap),
      .irq_alarm(irq_alarm), .irq_period(irq_period)
   );

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%h exp=%h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic ticks(input int n);
      @(negedge clk);
      tick = 1'b1;
      repeat (n) @(posedge clk);
      @(negedge clk);
      tick = 1'b0;
   endtask

   task automatic restart();
      wr(3'd0, 32'h4);
      wr(3'd0, 32'h0);
      wr(3'd6, 32'hFFFF_FFFF);
   endtask

   task automatic t_reset();
      logic [31:0] d;
      rd(3'd1, d); check("R1 reset lo", d, 0);
      rd(3'd2, d); check("R1 reset hi", d, 0);
      rd(3'd6, d); check("R7 reset status", d, 0);
      check("R10 reset irqs", {29'd0, irq_wrap, irq_alarm, irq_period}, 0);
   endtask

   task automatic t_step();
      logic [31:0] d;
      ticks(5);
      rd(3'd1, d); check("R1 step lo", d, 5);
   endtask

   task automatic t_clear();
      logic [31:0] d;
      wr(3'd0, 32'h4);
      ticks(3);
      rd(3'd1, d); check("R3 held lo", d, 0);
      rd(3'd2, d); check("R3 held hi", d, 0);
      rd(3'd0, d); check("R4 ctrl readback", d, 32'h4);
      wr(3'd0, 32'h0);
      ticks(2);
      rd(3'd1, d); check("R3 resume", d, 2);
   endtask

   task automatic t_freeze_lo();
      logic [31:0] d;
      restart();
      ticks(7);
      wr(3'd0, 32'h1);
      ticks(9);
      rd(3'd1, d); check("R2 lo frozen", d, 7);
      wr(3'd0, 32'h0);
      ticks(1);
      rd(3'd1, d); check("R2 lo thawed", d, 8);
   endtask

   task automatic t_carry_drop();
      logic [31:0] d;
      restart();
      ticks(255);
      wr(3'd0, 32'h2);
      ticks(1);
      rd(3'd1, d); check("R11 lo wrapped", d, 0);
      rd(3'd2, d); check("R11 hi kept", d, 0);
      rd(3'd6, d); check("R11 no wrap flag", d & S_WRAP, 0);
      wr(3'd0, 32'h0);
      ticks(256);
      rd(3'd2, d); check("R2 hi counts again", d, 1);
   endtask

   task automatic t_rollover();
      logic [31:0] d;
      restart();
      wr(3'd7, S_WRAP);
      ticks(4095);
      rd(3'd6, d); check("R8 no early wrap", d & S_WRAP, 0);
      ticks(1);
      rd(3'd6, d); check("R8 wrap status", d & S_WRAP, S_WRAP);
      rd(3'd1, d); check("R8 counter zero", d, 0);
      check("R10 irq_wrap", {31'd0, irq_wrap}, 1);
      wr(3'd6, 32'h0);
      rd(3'd6, d); check("R9 write 0 keeps", d & S_WRAP, S_WRAP);
      wr(3'd6, S_WRAP);
      rd(3'd6, d); check("R9 w1c clears", d & S_WRAP, 0);
      check("R10 irq_wrap low", {31'd0, irq_wrap}, 0);
   endtask

   task automatic t_alarm();
      logic [31:0] d;
      wr(3'd4, 32'hFFFF_FFF1);
      rd(3'd4, d); check("R6 alarm hi masked", d, 32'h1);
      wr(3'd3, 32'h10);
      wr(3'd7, S_ALARM);
      restart();
      ticks(271);
      rd(3'd6, d); check("R6 no early alarm", d & S_ALARM, 0);
      ticks(1);
      rd(3'd6, d); check("R6 alarm set", d & S_ALARM, S_ALARM);
      check("R10 irq_alarm", {31'd0, irq_alarm}, 1);
      wr(3'd6, S_ALARM);
      repeat (5) @(negedge clk);
      rd(3'd6, d); check("R12 idle no reset", d & S_ALARM, 0);
      wr(3'd0, 32'h1);
      ticks(3);
      rd(3'd6, d); check("R12 frozen no reset", d & S_ALARM, 0);
      wr(3'd0, 32'h0);
   endtask

   task automatic t_period();
      logic [31:0] d;
      wr(3'd5, 32'd3);
      wr(3'd7, S_PER);
      wr(3'd6, 32'hFFFF_FFFF);
      wr(3'd0, 32'h8);
      ticks(3);
      rd(3'd6, d); check("R5 before Nth", d & S_PER, 0);
      ticks(1);
      rd(3'd6, d); check("R5 expiry at N", d & S_PER, S_PER);
      check("R10 irq_period", {31'd0, irq_period}, 1);
      wr(3'd6, S_PER);
      ticks(3);
      rd(3'd6, d); check("R5 second before", d & S_PER, 0);
      ticks(1);
      rd(3'd6, d); check("R5 second expiry", d & S_PER, S_PER);
      wr(3'd6, S_PER);
      wr(3'd0, 32'h18);
      ticks(10);
      rd(3'd6, d); check("R4 frozen no expiry", d & S_PER, 0);
      wr(3'd0, 32'h0);
      ticks(10);
      rd(3'd6, d); check("R4 idle no expiry", d & S_PER, 0);
      wr(3'd7, 32'h0);
      wr(3'd0, 32'h8);
      ticks(4);
      rd(3'd6, d); check("R10 status without enable", d & S_PER, S_PER);
      check("R10 irq gated off", {31'd0, irq_period}, 0);
      wr(3'd0, 32'h0);
   endtask

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      #(20 * 150000);
      bad++;
      total++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_step();
      t_clear();
      t_freeze_lo();
      t_carry_drop();
      t_rollover();
      t_alarm();
      t_period();
      summary();
   end
endmodule